// File: doc/BRIEF.md
# Noise-Shaped Coarse Duty Modulator

This block drives one gate signal from a duty word that is far finer than its switching counter can express. The counter supports only fifty duty levels. A first-order error-feedback modulator sits in front of it: once per switching period it adds the residue left over from the previous period to the incoming duty word and splits the total into two parts. The integer part becomes the coarse level for the coming period. The fractional part is stored as the residue for the next one. Over many periods the mean high time tracks the fine word, and the truncation error is pushed toward high frequencies, where the output filter removes it.

The duty word is unsigned fixed point. Its upper bits give a whole number of coarse levels and its lower FRAC_W bits give the fraction of one level. With the default FRAC_W of 8 and fifty levels, the average resolution comes close to 14 bits. The count advances on an external tick (`step_en`), which sets the switching rate. The tick is normally a divided enable, at one modulator step per period. The block marks each new period with a one-cycle pulse.

Top module: `sd_dither_pwm`

## Requirements
- R1: After synchronous reset, and until the first tick, `pwm_out` and `period_start` are low, whatever the value of `duty_in`. The stored residue and the coarse level both start at zero.
- R2: The counter advances only on cycles with `step_en` high. A period lasts LEVELS-1 ticks (49 by default). `period_start` pulses for one cycle on the first cycle of every period, and the first tick after reset opens a period.
- R3: For an integer duty word (fraction bits zero) the output is high for exactly `duty_in >> FRAC_W` ticks of every period.
- R4: The fraction bits are carried as a residue from period to period. Starting from a zero residue, the high ticks summed over N periods equal floor(N * duty_in / 2^FRAC_W).
- R5: When the duty word plus the residue reaches LEVELS-1 levels or more, the level is clamped to LEVELS-1 and the residue is cleared to zero.
- R6: `duty_in` is sampled only at a period boundary. A change in mid-period leaves the high time of the current period unchanged.
- R7: A level of 0 holds `pwm_out` low for the whole period.
- R8: The top level, LEVELS-1, holds `pwm_out` high for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Counter tick; one PWM count per high cycle |
| duty_in | input | 14 | Duty word: upper 6 bits are whole levels, lower 8 bits are the fraction |
| pwm_out | output | 1 | Gate drive bit |
| period_start | output | 1 | One-cycle pulse on the first cycle of each period |

## Verification
The bench drives the duty word with several patterns and sums the high ticks, then compares the sum with the ideal average. Whole-level words show that the plain compare is right. Half, quarter and 1/256 fractions show that the residue is carried, including a 256-period run that must come out exact. Words at and above the ceiling separate a clamped level from a residue left uncleared. Separate tests change the duty word in mid-period to confirm it is sampled only at the boundary, and pause the tick to confirm that the count and the output both hold.

// File: rtl/sdpwm_pkg.sv
package sdpwm_pkg;

    localparam int DEF_LEVELS = 50;
    localparam int DEF_FRAC_W = 8;

    function automatic int level_bits(input int levels);
        return $clog2(levels);
    endfunction

    function automatic int ticks_per_period(input int levels);
        return levels - 1;
    endfunction

endpackage

// File: rtl/sd_err_quant.sv
module sd_err_quant
    import sdpwm_pkg::*;
#(
    parameter int LEVELS = DEF_LEVELS,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int LVL_W = level_bits(LEVELS),
    localparam int DUTY_W = LVL_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [LVL_W-1:0]  lvl_next,
    output logic [FRAC_W-1:0] resid_q
);

    localparam int MAX_LVL = LEVELS - 1;
    localparam logic [DUTY_W:0] CLAMP_SUM = (DUTY_W + 1)'(MAX_LVL * (2 ** FRAC_W));

    typedef struct packed {
        logic [LVL_W-1:0]  level;
        logic [FRAC_W-1:0] resid;
    } quant_t;

    logic [DUTY_W:0] sum;
    quant_t          q;

    always_comb begin
        sum = {1'b0, duty_in} + (DUTY_W + 1)'(resid_q);
        if (sum >= CLAMP_SUM) begin
            q.level = LVL_W'(MAX_LVL);
            q.resid = '0;
        end else begin
            q.level = LVL_W'(sum >> FRAC_W);
            q.resid = sum[FRAC_W-1:0];
        end
    end

    assign lvl_next = q.level;

    always_ff @(posedge clk) begin
        if (rst) begin
            resid_q <= '0;
        end else if (load) begin
            resid_q <= q.resid;
        end
    end

endmodule

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter
    import sdpwm_pkg::*;
#(
    parameter int LEVELS = DEF_LEVELS,
    localparam int LVL_W = level_bits(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    output logic [LVL_W-1:0] cnt_q,
    output logic             wrap,
    output logic             period_start
);

    localparam logic [LVL_W-1:0] LAST = LVL_W'(ticks_per_period(LEVELS) - 1);

    assign wrap = step_en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= LAST;
            period_start <= 1'b0;
        end else begin
            period_start <= wrap;
            if (wrap) begin
                cnt_q <= '0;
            end else if (step_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_level_cmp.sv
module pwm_level_cmp
    import sdpwm_pkg::*;
#(
    parameter int LEVELS = DEF_LEVELS,
    localparam int LVL_W = level_bits(LEVELS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LVL_W-1:0] lvl_next,
    input  logic [LVL_W-1:0] cnt,
    output logic [LVL_W-1:0] lvl_q,
    output logic             pwm_out
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (load) begin
            lvl_q <= lvl_next;
        end
    end

    assign pwm_out = (cnt < lvl_q);

endmodule

// File: rtl/sd_dither_pwm.sv
module sd_dither_pwm
    import sdpwm_pkg::*;
#(
    parameter int LEVELS = DEF_LEVELS,
    parameter int FRAC_W = DEF_FRAC_W,
    localparam int LVL_W = level_bits(LEVELS),
    localparam int DUTY_W = LVL_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              pwm_out,
    output logic              period_start
);

    logic [LVL_W-1:0]  cnt_q;
    logic [LVL_W-1:0]  lvl_next;
    logic [LVL_W-1:0]  lvl_q;
    logic [FRAC_W-1:0] resid_q;
    logic              wrap;

    pwm_tick_counter #(.LEVELS(LEVELS)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .step_en      (step_en),
        .cnt_q        (cnt_q),
        .wrap         (wrap),
        .period_start (period_start)
    );

    sd_err_quant #(.LEVELS(LEVELS), .FRAC_W(FRAC_W)) u_quant (
        .clk      (clk),
        .rst      (rst),
        .load     (wrap),
        .duty_in  (duty_in),
        .lvl_next (lvl_next),
        .resid_q  (resid_q)
    );

    pwm_level_cmp #(.LEVELS(LEVELS)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .load     (wrap),
        .lvl_next (lvl_next),
        .cnt      (cnt_q),
        .lvl_q    (lvl_q),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/sd_dither_pwm_chk.sv
module sd_dither_pwm_chk #(
    parameter int LEVELS = 50,
    parameter int FRAC_W = 8,
    parameter int LVL_W  = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              step_en,
    input logic              pwm_out,
    input logic              period_start,
    input logic [LVL_W-1:0]  cnt,
    input logic [LVL_W-1:0]  lvl,
    input logic [FRAC_W-1:0] resid
);

    localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(LEVELS - 1);

    // R2: no tick, no count movement
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(cnt));

    // R2: the period marker lasts exactly one cycle
    a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
        period_start |=> !period_start);

    // R6: the latched level only moves at a boundary
    a_r6_level_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl) |-> period_start);

    // R5: level never exceeds the ceiling
    a_r5_level_ceiling: assert property (@(posedge clk) disable iff (rst)
        lvl <= MAX_LVL);

    // R5: a ceiling level leaves no residue behind
    a_r5_resid_cleared: assert property (@(posedge clk) disable iff (rst)
        (period_start && lvl == MAX_LVL) |-> resid == '0);

    // R8: top level drives high throughout
    a_r8_full_high: assert property (@(posedge clk) disable iff (rst)
        (lvl == MAX_LVL) |-> pwm_out);

    // R7: zero level drives low throughout
    a_r7_zero_low: assert property (@(posedge clk) disable iff (rst)
        (lvl == '0) |-> !pwm_out);

endmodule

bind sd_dither_pwm sd_dither_pwm_chk #(
    .LEVELS (LEVELS),
    .FRAC_W (FRAC_W),
    .LVL_W  (LVL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .step_en      (step_en),
    .pwm_out      (pwm_out),
    .period_start (period_start),
    .cnt          (cnt_q),
    .lvl          (lvl_q),
    .resid        (resid_q)
);

// File: tb/sd_dither_pwm_tb.sv
module sd_dither_pwm_tb;

    localparam int TICKS  = 49;
    localparam int DUTY_W = 14;
    localparam int NVEC   = 8;

    // duty word, periods, expected total high ticks, requirement
    localparam int TV_DUTY [NVEC] = '{0,   12544, 2560, 2688, 1281, 320, 16383, 12543};
    localparam int TV_N    [NVEC] = '{4,   4,     3,    4,    256,  8,   3,     8};
    localparam int TV_EXP  [NVEC] = '{0,   196,   30,   42,   1281, 10,  147,   388};
    localparam string TV_REQ [NVEC] = '{"R7", "R8", "R3", "R4", "R4", "R4", "R5", "R5"};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step_en = 1'b0;
    logic [DUTY_W-1:0] duty = '0;
    logic              pwm_out;
    logic              period_start;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sd_dither_pwm u_dut (
        .clk          (clk),
        .rst          (rst),
        .step_en      (step_en),
        .duty_in      (duty),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        step_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // first tick after reset loads the opening period
    task automatic prime();
        step_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    // sample n whole periods; next_duty is applied before the final boundary
    task automatic run(input int n, input int next_duty, output int hi, output int starts);
        hi = 0;
        starts = 0;
        step_en = 1'b1;
        for (int i = 0; i < n * TICKS; i++) begin
            if (pwm_out) hi++;
            if (period_start) starts++;
            if (i == n * TICKS - 1) duty = DUTY_W'(next_duty);
            @(posedge clk);
            @(negedge clk);
        end
        step_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        int hi;
        int starts;
        int held;
        int stray;

        // R1: reset state holds without a tick
        duty = DUTY_W'(12544);
        do_reset();
        held = 0;
        for (int i = 0; i < 5; i++) begin
            if (pwm_out || period_start) held++;
            @(negedge clk);
        end
        check("R1 idle outputs after reset", held, 0);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            duty = DUTY_W'(TV_DUTY[v]);
            do_reset();
            prime();
            check("R2 first sample marks period", int'(period_start), 1);
            run(TV_N[v], TV_DUTY[v], hi, starts);
            check(TV_REQ[v], hi, TV_EXP[v]);
            check("R2 period count", starts, TV_N[v]);
        end

        // R5: residue cleared after clamp (2760 = 10 levels + 200/256)
        duty = DUTY_W'(16383);
        do_reset();
        prime();
        run(1, 2760, hi, starts);
        check("R5 clamped period", hi, 49);
        run(1, 2760, hi, starts);
        check("R5 residue cleared after clamp", hi, 10);
        run(1, 2760, hi, starts);
        check("R4 residue carried after clamp", hi, 11);

        // R6: mid-period change ignored until boundary
        duty = DUTY_W'(20 * 256);
        do_reset();
        prime();
        hi = 0;
        for (int i = 0; i < TICKS; i++) begin
            if (pwm_out) hi++;
            if (i == 10) duty = '0;
            @(posedge clk);
            @(negedge clk);
        end
        check("R6 high ticks with mid-period change", hi, 20);
        run(1, 0, hi, starts);
        check("R6 new duty in next period", hi, 0);

        // R2: pausing the tick freezes output and count
        duty = DUTY_W'(25 * 256);
        do_reset();
        prime();
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            if (pwm_out) hi++;
            @(posedge clk);
            @(negedge clk);
        end
        step_en = 1'b0;
        held = int'(pwm_out);
        stray = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (int'(pwm_out) != held || period_start) stray++;
        end
        check("R2 frozen while tick low", stray, 0);
        step_en = 1'b1;
        for (int i = 10; i < TICKS; i++) begin
            if (pwm_out) hi++;
            @(posedge clk);
            @(negedge clk);
        end
        step_en = 1'b0;
        check("R2 R3 paused period high ticks", hi, 25);

        finish_run();
    end

endmodule